// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block sits between a UART receiver, the receive FIFO and the UART transmitter, and handles in-band flow control. It checks each received character against four programmable flow-control characters. A match can be on one character, or on a pair of consecutive characters. Characters that are consumed as flow-control matches are removed from the data path. On an Xoff match it raises a status flag and asks the local transmitter to pause. A matching Xon, or any character when the resume-on-any option is set, lifts the pause. The transmitter only samples `tx_pause` at a character boundary, so a character already being shifted out always completes.

In the other direction, the block watches the fill level of the local receive FIFO against a trigger level. It asks the transmitter to insert an Xoff when the level rises above the trigger, and an Xon when the level falls below it again. A separate special-character mode only compares incoming characters against the second Xoff value and still passes every character on. All character comparisons cover only the low 5 to 8 bits, as set by the programmed word length.

Received characters arrive as single-cycle `rx_valid` strobes that are at least three clock cycles apart. This is always true for a serial line running far below the core clock.

Top module: `xonxoff_ctl`

## Requirements
- R1: Comparisons use only the low N bits of each character. N is 5, 6, 7 or 8 for `wlen` = 00, 01, 10 or 11. Bit 0 is the first data bit received. Characters that differ only above bit N-1 count as equal.
- R2: In single mode (`mode` = 01), a character equal to `xoff1_chr` is discarded: `discard` pulses in the cycle after `rx_valid` and nothing is forwarded. `xoff_flag` and `tx_pause` are set in that same cycle.
- R3: In single mode, a character equal to `xon1_chr` is discarded and clears `xoff_flag` and `tx_pause`.
- R4: In double mode (`mode` = 10), `xoff1_chr` followed directly by `xoff2_chr` sets the flag, and the pair `xon1_chr` then `xon2_chr` clears it. Neither character of a matched pair is forwarded, and `discard` pulses once, after the second character.
- R5: In double mode, when a held first character is followed by a character that does not complete its pair, the held character is forwarded in the cycle after the second strobe. The second character is forwarded one cycle later, unless it starts a new pair, in which case it is held in turn.
- R6: With `xon_any` = 1 in single or double mode, any received character that does not complete an Xoff match clears `xoff_flag`. An Xoff match still sets it.
- R7: In special mode (`mode` = 11), every character is forwarded unchanged. A character equal to `xoff2_chr` sets `xoff_flag`. `tx_pause` stays low and nothing is discarded.
- R8: `xoff_irq` is high only while `xoff_flag` is set and `xoff_irq_en` is 1.
- R9: A character that is not consumed appears on `fwd_data` with all 8 bits intact, with `fwd_valid` high for one cycle. `fwd_valid` and `discard` are never high in the same cycle.
- R10: In single or double mode, `ins_req` rises with `ins_xon` = 0 when `rx_level` > `rx_trig`. It rises with `ins_xon` = 1 when the level later drops below `rx_trig`. A level equal to the trigger changes nothing. The request holds until `ins_ack` is sampled high.
- R11: A pending insert that is still unacknowledged is cancelled, with no new request, when the level crosses back the other way.
- R12: In off mode (`mode` = 00), every character is forwarded, `xoff_flag` is cleared and no insert is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe marking a received character |
| rx_data | input | 8 | Received character |
| mode | input | 2 | 00 off, 01 single, 10 double, 11 special |
| wlen | input | 2 | Word length code, 5 to 8 bits |
| xon_any | input | 1 | Any received character resumes transmission |
| xoff_irq_en | input | 1 | Enables the Xoff interrupt request |
| xon1_chr | input | 8 | First Xon character |
| xon2_chr | input | 8 | Second Xon character |
| xoff1_chr | input | 8 | First Xoff character |
| xoff2_chr | input | 8 | Second Xoff character, also the special character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| ins_ack | input | 1 | Transmitter has taken the insert request |
| fwd_valid | output | 1 | Write strobe toward the receive FIFO |
| fwd_data | output | 8 | Character written toward the receive FIFO |
| discard | output | 1 | A flow-control match consumed received characters |
| xoff_flag | output | 1 | Xoff state or special-character status |
| xoff_irq | output | 1 | Interrupt request for the Xoff flag |
| tx_pause | output | 1 | Transmitter pauses at the next character boundary |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_xon | output | 1 | Kind of insert: 1 Xon, 0 Xoff |

## Verification
The hardest state to reach from the ports is a release in double mode whose second character itself opens a new pair. In that case the first held character has to leave while its successor takes the hold slot, and the third character then completes the match. The bench gets there by sending Xoff1, Xoff1, Xoff2 in a row. It then checks the forwarded byte after the second strobe and the flag after the third. The other hard case is the insert cancellation. The bench moves `rx_level` across the trigger and back while keeping `ins_ack` low, then crosses again to show that the internal "remote is off" state followed the cancellation.

// File: rtl/xoxf_pkg.sv
package xoxf_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    FM_OFF     = 2'b00,
    FM_SINGLE  = 2'b01,
    FM_DOUBLE  = 2'b10,
    FM_SPECIAL = 2'b11
  } fmode_e;

  // Mask of the significant bits for a word-length code (5..8 bits).
  function automatic logic [CHAR_W-1:0] wl_mask(input logic [1:0] wl);
    return {CHAR_W{1'b1}} >> (2'd3 - wl);
  endfunction

  // Equality restricted to the programmed word length.
  function automatic logic chr_eq(input logic [CHAR_W-1:0] a,
                                  input logic [CHAR_W-1:0] b,
                                  input logic [1:0]        wl);
    return ((a ^ b) & wl_mask(wl)) == '0;
  endfunction
endpackage

// File: rtl/xoxf_rxmatch.sv
module xoxf_rxmatch
  import xoxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [1:0]        mode,
  input  logic [1:0]        wlen,
  input  logic              xon_any,
  input  logic [CHAR_W-1:0] xon1_chr,
  input  logic [CHAR_W-1:0] xon2_chr,
  input  logic [CHAR_W-1:0] xoff1_chr,
  input  logic [CHAR_W-1:0] xoff2_chr,
  output logic              fwd_valid,
  output logic [CHAR_W-1:0] fwd_data,
  output logic              discard,
  output logic              xoff_flag
);
  fmode_e fm;
  assign fm = fmode_e'(mode);

  logic              held_v, held_xoff, pend_v;
  logic [CHAR_W-1:0] held_q, pend_q;

  logic hit_off1, hit_on1, hit_off2, hit_on2;
  assign hit_off1 = chr_eq(rx_data, xoff1_chr, wlen);
  assign hit_on1  = chr_eq(rx_data, xon1_chr,  wlen);
  assign hit_off2 = chr_eq(rx_data, xoff2_chr, wlen);
  assign hit_on2  = chr_eq(rx_data, xon2_chr,  wlen);

  // Named events for the checks below.
  logic second_hit, rel_evt;
  assign second_hit = held_v && (held_xoff ? hit_off2 : hit_on2);
  assign rel_evt    = rx_valid && (fm == FM_DOUBLE) && held_v && !second_hit;

  logic              n_fwd, n_disc, n_set, n_clr;
  logic [CHAR_W-1:0] n_fdata, n_held_q, n_pend_q;
  logic              n_held_v, n_held_xoff, n_pend_v;

  always_comb begin
    n_fwd       = 1'b0;
    n_fdata     = rx_data;
    n_disc      = 1'b0;
    n_set       = 1'b0;
    n_clr       = 1'b0;
    n_held_v    = held_v;
    n_held_xoff = held_xoff;
    n_held_q    = held_q;
    n_pend_v    = 1'b0;
    n_pend_q    = pend_q;
    if (pend_v) begin
      n_fwd   = 1'b1;
      n_fdata = pend_q;
    end
    if (rx_valid) begin
      unique case (fm)
        FM_OFF: begin
          n_fwd   = 1'b1;
          n_fdata = rx_data;
        end
        FM_SINGLE: begin
          if (hit_off1) begin
            n_disc = 1'b1;
            n_set  = 1'b1;
          end else if (hit_on1) begin
            n_disc = 1'b1;
            n_clr  = 1'b1;
          end else begin
            n_fwd   = 1'b1;
            n_fdata = rx_data;
            n_clr   = xon_any;
          end
        end
        FM_DOUBLE: begin
          if (second_hit) begin
            n_disc   = 1'b1;
            n_held_v = 1'b0;
            n_set    = held_xoff;
            n_clr    = !held_xoff;
          end else begin
            if (held_v) begin
              n_fwd   = 1'b1;
              n_fdata = held_q;
            end
            if (hit_off1 || hit_on1) begin
              n_held_v    = 1'b1;
              n_held_xoff = hit_off1;
              n_held_q    = rx_data;
            end else if (held_v) begin
              n_held_v = 1'b0;
              n_pend_v = 1'b1;
              n_pend_q = rx_data;
            end else begin
              n_fwd   = 1'b1;
              n_fdata = rx_data;
            end
          end
          if (xon_any && !n_set) n_clr = 1'b1;
        end
        FM_SPECIAL: begin
          n_fwd   = 1'b1;
          n_fdata = rx_data;
          n_set   = hit_off2;
        end
      endcase
    end
    if (fm != FM_DOUBLE) n_held_v = 1'b0;
    if (fm == FM_OFF)    n_clr    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      discard   <= 1'b0;
      xoff_flag <= 1'b0;
      held_v    <= 1'b0;
      held_xoff <= 1'b0;
      held_q    <= '0;
      pend_v    <= 1'b0;
      pend_q    <= '0;
    end else begin
      fwd_valid <= n_fwd;
      fwd_data  <= n_fdata;
      discard   <= n_disc;
      held_v    <= n_held_v;
      held_xoff <= n_held_xoff;
      held_q    <= n_held_q;
      pend_v    <= n_pend_v;
      pend_q    <= n_pend_q;
      if (n_set)      xoff_flag <= 1'b1;
      else if (n_clr) xoff_flag <= 1'b0;
    end
  end

  // R9: a character is either forwarded or consumed, never both at once.
  p_fwd_or_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && discard));

  // R2: a discard always follows a received character.
  p_drop_after_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> $past(rx_valid));

  // R2: the flag only rises in response to a received character.
  p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_flag) |-> $past(rx_valid));

  // R5: a released held character comes out next, unchanged.
  p_release_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> (fwd_valid && fwd_data == $past(held_q)));

  // R7: special mode never consumes characters.
  p_special_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fm == FM_SPECIAL && $past(fm) == FM_SPECIAL) |-> !discard);
endmodule

// File: rtl/xoxf_insert.sv
module xoxf_insert #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             ins_ack,
  output logic             ins_req,
  output logic             ins_xon
);
  logic remote_off;
  logic above, below, cancel_evt;

  assign above = rx_level > rx_trig;
  assign below = rx_level < rx_trig;
  // An opposite crossing while a request is still unsent withdraws it.
  assign cancel_evt = ins_req && !ins_ack &&
                      ((remote_off && below && !ins_xon) ||
                       (!remote_off && above && ins_xon));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remote_off <= 1'b0;
      ins_req    <= 1'b0;
      ins_xon    <= 1'b0;
    end else if (!en) begin
      remote_off <= 1'b0;
      ins_req    <= 1'b0;
    end else begin
      if (ins_req && ins_ack) ins_req <= 1'b0;
      if (!remote_off && above) begin
        remote_off <= 1'b1;
        if (cancel_evt) ins_req <= 1'b0;
        else begin
          ins_req <= 1'b1;
          ins_xon <= 1'b0;
        end
      end else if (remote_off && below) begin
        remote_off <= 1'b0;
        if (cancel_evt) ins_req <= 1'b0;
        else begin
          ins_req <= 1'b1;
          ins_xon <= 1'b1;
        end
      end
    end
  end

  // R10: an unacknowledged request stays up unless it is cancelled.
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ins_req && !ins_ack && !cancel_evt) |=> ins_req);

  // R10: the kind of a pending request does not change under it.
  p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ins_req && !ins_ack && !cancel_evt) |=> $stable(ins_xon));

  // R11: a cancellation leaves no request behind.
  p_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cancel_evt) |=> !ins_req);
endmodule

// File: rtl/xonxoff_ctl.sv
module xonxoff_ctl
  import xoxf_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [1:0]       mode,
  input  logic [1:0]       wlen,
  input  logic             xon_any,
  input  logic             xoff_irq_en,
  input  logic [7:0]       xon1_chr,
  input  logic [7:0]       xon2_chr,
  input  logic [7:0]       xoff1_chr,
  input  logic [7:0]       xoff2_chr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             ins_ack,
  output logic             fwd_valid,
  output logic [7:0]       fwd_data,
  output logic             discard,
  output logic             xoff_flag,
  output logic             xoff_irq,
  output logic             tx_pause,
  output logic             ins_req,
  output logic             ins_xon
);
  logic flow_on;
  assign flow_on = (fmode_e'(mode) == FM_SINGLE) || (fmode_e'(mode) == FM_DOUBLE);

  xoxf_rxmatch u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .mode      (mode),
    .wlen      (wlen),
    .xon_any   (xon_any),
    .xon1_chr  (xon1_chr),
    .xon2_chr  (xon2_chr),
    .xoff1_chr (xoff1_chr),
    .xoff2_chr (xoff2_chr),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data),
    .discard   (discard),
    .xoff_flag (xoff_flag)
  );

  xoxf_insert #(.LVL_W(LVL_W)) u_ins (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (flow_on),
    .rx_level (rx_level),
    .rx_trig  (rx_trig),
    .ins_ack  (ins_ack),
    .ins_req  (ins_req),
    .ins_xon  (ins_xon)
  );

  assign tx_pause = xoff_flag && flow_on;
  assign xoff_irq = xoff_flag && xoff_irq_en;

  // R2: the transmitter is never paused without the Xoff state behind it.
  p_pause_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pause |-> xoff_flag);

  // R12: off mode never issues an insert request one cycle on.
  p_off_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && $past(mode) == 2'b00) |-> !ins_req);
endmodule

// File: tb/sim_xonxoff_ctl.sv
module sim_xonxoff_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [1:0] mode = 2'b00;
  logic [1:0] wlen = 2'b11;
  logic       xon_any = 1'b0;
  logic       xoff_irq_en = 1'b0;
  logic [7:0] xon1_chr = 8'h13, xon2_chr = 8'h0C, xoff1_chr = 8'hF5, xoff2_chr = 8'hEA;
  logic [6:0] rx_level = 7'd0, rx_trig = 7'd8;
  logic       ins_ack = 1'b0;
  logic       fwd_valid, discard, xoff_flag, xoff_irq, tx_pause, ins_req, ins_xon;
  logic [7:0] fwd_data;

  int n_run = 0, n_fail = 0;
  logic       o1_fwd, o1_disc, o2_fwd;
  logic [7:0] o1_data, o2_data;

  always #4 clk = ~clk;

  xonxoff_ctl #(.LVL_W(7)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] ch);
    @(negedge clk); rx_valid = 1'b1; rx_data = ch;
    @(negedge clk); rx_valid = 1'b0;
    o1_fwd = fwd_valid; o1_data = fwd_data; o1_disc = discard;
    @(negedge clk); o2_fwd = fwd_valid; o2_data = fwd_data;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = 2'b00;
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R9 fwd", fwd_valid, 0);
    chk("reset R2 flag", xoff_flag, 0);
    chk("reset R10 req", ins_req, 0);
    rst_n = 1'b1;

    // R1/R2/R3/R9 sweep: single bit flips of xoff1 over every word length
    set_mode(2'b01);
    for (int w = 0; w < 4; w++) begin
      wlen = w[1:0];
      for (int b = 0; b < 8; b++) begin
        logic hit;
        logic [7:0] ch;
        hit = (b >= 5 + w);
        ch  = xoff1_chr ^ (8'h01 << b);
        send(ch);
        chk("R1 discard", o1_disc, hit);
        chk("R9 fwd", o1_fwd, !hit);
        if (!hit) chk("R9 data", o1_data, ch);
        chk("R2 flag", xoff_flag, hit);
        chk("R2 pause", tx_pause, hit);
        if (hit) begin
          send(xon1_chr ^ 8'h80 ^ (w == 3 ? 8'h80 : 8'h00));
          chk("R3 discard", o1_disc, 1);
          chk("R3 flag", xoff_flag, 0);
        end
      end
    end
    wlen = 2'b11;

    // R8: interrupt gating
    send(xoff1_chr);
    chk("R8 irq off", xoff_irq, 0);
    @(negedge clk); xoff_irq_en = 1'b1;
    @(negedge clk); chk("R8 irq on", xoff_irq, 1);
    send(xon1_chr);
    chk("R8 irq clear", xoff_irq, 0);

    // R6: resume on any character
    xon_any = 1'b1;
    send(xoff1_chr);
    chk("R6 set", xoff_flag, 1);
    send(8'h40);
    chk("R6 fwd", o1_fwd, 1);
    chk("R6 clear", xoff_flag, 0);
    xon_any = 1'b0;

    // R4/R5: double mode
    set_mode(2'b10);
    send(xoff1_chr);
    chk("R4 held", o1_fwd | o1_disc, 0);
    send(xoff2_chr);
    chk("R4 discard", o1_disc, 1);
    chk("R4 flag", xoff_flag, 1);
    chk("R4 pause", tx_pause, 1);
    send(xon1_chr);
    chk("R4 xon held", o1_fwd | o1_disc, 0);
    send(xon2_chr);
    chk("R4 xon discard", o1_disc, 1);
    chk("R4 xon flag", xoff_flag, 0);
    send(xoff1_chr);
    send(8'h40);
    chk("R5 first fwd", o1_fwd, 1);
    chk("R5 first data", o1_data, xoff1_chr);
    chk("R5 second fwd", o2_fwd, 1);
    chk("R5 second data", o2_data, 8'h40);
    chk("R5 no flag", xoff_flag, 0);
    send(xoff1_chr);
    send(xoff1_chr);
    chk("R5 rehold fwd", o1_fwd, 1);
    chk("R5 rehold data", o1_data, xoff1_chr);
    chk("R5 rehold no second", o2_fwd, 0);
    send(xoff2_chr);
    chk("R5 rehold match", o1_disc, 1);
    chk("R5 rehold flag", xoff_flag, 1);
    send(xon1_chr);
    send(xon2_chr);
    chk("R4 final clear", xoff_flag, 0);

    // R7: special mode
    set_mode(2'b11);
    send(xoff2_chr);
    chk("R7 fwd", o1_fwd, 1);
    chk("R7 data", o1_data, xoff2_chr);
    chk("R7 flag", xoff_flag, 1);
    chk("R7 pause", tx_pause, 0);
    send(xoff1_chr);
    chk("R7 xoff1 kept", o1_fwd, 1);
    chk("R7 no discard", o1_disc, 0);

    // R12: off mode
    @(negedge clk); mode = 2'b00;
    @(negedge clk); chk("R12 flag clear", xoff_flag, 0);
    send(xoff1_chr);
    chk("R12 fwd", o1_fwd, 1);
    rx_level = 7'd20;
    repeat (2) @(negedge clk);
    chk("R12 no req", ins_req, 0);
    rx_level = 7'd0;

    // R10/R11: insertion requests
    set_mode(2'b01);
    rx_level = 7'd8;
    repeat (2) @(negedge clk);
    chk("R10 equal no req", ins_req, 0);
    rx_level = 7'd9;
    @(negedge clk);
    chk("R10 xoff req", ins_req, 1);
    chk("R10 xoff kind", ins_xon, 0);
    repeat (3) @(negedge clk);
    chk("R10 held", ins_req, 1);
    ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
    chk("R10 acked", ins_req, 0);
    rx_level = 7'd7;
    @(negedge clk);
    chk("R10 xon req", ins_req, 1);
    chk("R10 xon kind", ins_xon, 1);
    ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
    chk("R10 xon acked", ins_req, 0);
    rx_level = 7'd9;
    @(negedge clk);
    chk("R11 xoff pending", ins_req, 1);
    rx_level = 7'd7;
    @(negedge clk);
    chk("R11 cancelled", ins_req, 0);
    repeat (2) @(negedge clk);
    chk("R11 no xon", ins_req, 0);
    rx_level = 7'd9;
    @(negedge clk);
    chk("R11 rearmed", ins_req, 1);
    chk("R11 rearmed kind", ins_xon, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule